// File: doc/BRIEF.md
# Buffered Serial Transmitter with Dual-Empty Interrupts

This block turns bytes written by a processor into an asynchronous serial stream. Bytes enter a 16-deep queue through a one-cycle write strobe. A framing engine takes the oldest byte from the queue whenever it has nothing to send, or right after finishing a stop bit. It then drives a low start bit, the data bits least significant first and a high stop bit onto a line that otherwise rests high. A programmable divisor of the system clock sets the length of each bit. A length select chooses frames with seven or eight data bits.

Two status flags tell software how far the data has drained. The queue-drained flag means no further byte is waiting. The shifter-idle flag means the last frame has fully left the line. Each flag has its own enable. An enabled flag drives its bit in a two-bit cause vector, and the two cause bits are ORed onto a single interrupt output. A write that finds the queue full is discarded and sets a sticky overflow indication, which only reset clears.

Top module: `uart_tx_fifo`

## Requirements
- R1: After reset the line is high, both flags are set, the overflow indication is clear, and with both enables low the interrupt and both cause bits are low.
- R2: Every start, data and stop bit lasts exactly `divisor` clock cycles, and a divisor of 0 acts as 1.
- R3: A frame is one low start bit, then data bits from bit 0 upward (eight bits when `len8`=1, bits 0 to 6 when `len8`=0, so bit 7 is ignored), then one high stop bit. The line is high whenever no frame is in progress.
- R4: A byte written while the shifter is idle clears the queue-drained flag at the write edge. At the next edge the byte loads into the shifter, the shifter-idle flag clears and the start bit begins.
- R5: Queued bytes are sent in write order. When the queue holds a byte at the end of a stop bit, the next start bit follows with no idle cycle.
- R6: At the end of a stop bit, the queue-drained flag is set if the queue held at most one byte (none, or the one now moving into the shifter). Otherwise it stays clear.
- R7: The shifter-idle flag stays clear through the whole stop bit. It is set at the end of the stop bit only when the queue held no byte.
- R8: `irq_cause[0]` = queue-drained AND `buf_irq_en`, `irq_cause[1]` = shifter-idle AND `shf_irq_en`, and `irq` is the OR of the two cause bits.
- R9: The queue stores 16 bytes. A write while it holds 16 is dropped, and it sets `overflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to queue |
| divisor | input | 16 | Clock cycles per serial bit |
| len8 | input | 1 | 1: eight data bits, 0: seven |
| buf_irq_en | input | 1 | Enable for the queue-drained cause |
| shf_irq_en | input | 1 | Enable for the shifter-idle cause |
| tx_line | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Queue-drained flag |
| shf_empty | output | 1 | Shifter-idle flag |
| overflow | output | 1 | Sticky dropped-write indication |
| irq | output | 1 | Combined interrupt |
| irq_cause | output | 2 | Per-cause interrupt bits |

## Verification
The hardest state to reach is a full queue while a frame is still on the line. The shifter drains one byte per frame, so the queue only fills if the writes outrun it. The stimulus therefore sets a four-cycle bit period and writes eighteen bytes on consecutive cycles. Only the first byte leaves the queue before the seventeenth arrives, so the eighteenth write meets a full queue. The bench then checks that exactly seventeen frames come out. A second delicate point is the stop-bit boundary between queued frames. Short bursts with chosen depths check the flags on the exact cycles before and after that edge.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } frame_st_e;

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_s;

    baud_s q, d;
    logic [DIV_W-1:0] last_cnt;

    always_comb begin
        // a zero divisor behaves like one cycle per bit
        last_cnt = (divisor_i == '0) ? '0 : divisor_i - DIV_W'(1);
        tick_o   = run_i && (q.cnt == last_cnt);
        d        = q;
        if (restart_i || !run_i || tick_o) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_s;

    fifo_s q, d;
    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d = q;
        if (push_i) begin
            d.wp = bump(q.wp);
        end
        if (pop_i) begin
            d.rp = bump(q.rp);
        end
        case ({push_i, pop_i})
            2'b10:   d.cnt = q.cnt + CNT_W'(1);
            2'b01:   d.cnt = q.cnt - CNT_W'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[q.wp] <= din_i;
        end
    end

    assign head_o  = mem[q.rp];
    assign count_o = q.cnt;

endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import utx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              avail_i,
    input  logic [DATA_W-1:0] head_i,
    input  logic              wide_i,
    output logic              pop_o,
    output logic              busy_o,
    output logic              stop_done_o,
    output logic              tx_o
);

    typedef struct packed {
        frame_st_e         st;
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
        logic              wide;
    } frame_s;

    frame_s q, d;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        d           = q;
        pop_o       = 1'b0;
        stop_done_o = 1'b0;
        // full-width frames stop after bit DATA_W-1, short ones one bit earlier
        last_idx    = q.wide ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
        case (q.st)
            ST_IDLE: begin
                if (avail_i) begin
                    pop_o  = 1'b1;
                    d.st   = ST_START;
                    d.sh   = head_i;
                    d.wide = wide_i;
                    d.idx  = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    d.st  = ST_DATA;
                    d.idx = '0;
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    d.sh = q.sh >> 1;
                    if (q.idx == last_idx) begin
                        d.st = ST_STOP;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    stop_done_o = 1'b1;
                    if (avail_i) begin
                        pop_o  = 1'b1;
                        d.st   = ST_START;
                        d.sh   = head_i;
                        d.wide = wide_i;
                        d.idx  = '0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sh: '0, idx: '0, wide: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            ST_START: tx_o = 1'b0;
            ST_DATA:  tx_o = q.sh[0];
            default:  tx_o = 1'b1;
        endcase
    end

    assign busy_o = (q.st != ST_IDLE);

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              len8,
    input  logic              buf_irq_en,
    input  logic              shf_irq_en,
    output logic              tx_line,
    output logic              buf_empty,
    output logic              shf_empty,
    output logic              overflow,
    output logic              irq,
    output logic [1:0]        irq_cause
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic buf_empty;
        logic shf_empty;
        logic ovf;
    } flags_s;

    flags_s q, d;

    logic [CNT_W-1:0]  fifo_cnt;
    logic [DATA_W-1:0] fifo_head;
    logic              fifo_full;
    logic              push_ok;
    logic              pop;
    logic              busy;
    logic              tick;
    logic              stop_done;

    assign fifo_full = (fifo_cnt == CNT_W'(DEPTH));
    assign push_ok   = wr_en && !fifo_full;

    utx_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_ok),
        .din_i   (wr_data),
        .pop_i   (pop),
        .head_o  (fifo_head),
        .count_o (fifo_cnt)
    );

    utx_baud #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy),
        .restart_i (pop),
        .divisor_i (divisor),
        .tick_o    (tick)
    );

    utx_framer #(
        .DATA_W (DATA_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .avail_i     (fifo_cnt != '0),
        .head_i      (fifo_head),
        .wide_i      (len8),
        .pop_o       (pop),
        .busy_o      (busy),
        .stop_done_o (stop_done),
        .tx_o        (tx_line)
    );

    always_comb begin
        d = q;
        if (wr_en && fifo_full) begin
            d.ovf = 1'b1;
        end
        // stop-bit end: queue empty, or its last byte moves into the shifter
        if (stop_done && (fifo_cnt <= CNT_W'(1))) begin
            d.buf_empty = 1'b1;
        end
        if (push_ok) begin
            d.buf_empty = 1'b0;
        end
        if (pop) begin
            d.shf_empty = 1'b0;
        end else if (stop_done) begin
            d.shf_empty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{buf_empty: 1'b1, shf_empty: 1'b1, ovf: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign buf_empty    = q.buf_empty;
    assign shf_empty    = q.shf_empty;
    assign overflow     = q.ovf;
    assign irq_cause[0] = q.buf_empty && buf_irq_en;
    assign irq_cause[1] = q.shf_empty && shf_irq_en;
    assign irq          = |irq_cause;

endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             tx_line,
    input logic             shf_empty,
    input logic             overflow,
    input logic             irq,
    input logic             buf_irq_en,
    input logic             shf_irq_en,
    input logic [CNT_W-1:0] fifo_cnt
);

    // R3
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shf_empty |-> tx_line);

    // R4
    load_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shf_empty) |-> !tx_line);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9
    full_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_cnt == CNT_W'(DEPTH)) |=> overflow);

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_irq_en && !shf_irq_en) |-> !irq);

endmodule

bind uart_tx_fifo utx_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .tx_line    (tx_line),
    .shf_empty  (shf_empty),
    .overflow   (overflow),
    .irq        (irq),
    .buf_irq_en (buf_irq_en),
    .shf_irq_en (shf_irq_en),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/uart_tx_fifo_test.sv
module uart_tx_fifo_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] divisor = 16'd1;
    logic        len8 = 1'b1;
    logic        buf_irq_en = 1'b0;
    logic        shf_irq_en = 1'b0;
    logic        tx_line;
    logic        buf_empty;
    logic        shf_empty;
    logic        overflow;
    logic        irq;
    logic [1:0]  irq_cause;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] pat [0:31];
    logic samp [0:1023];

    uart_tx_fifo uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .divisor    (divisor),
        .len8       (len8),
        .buf_irq_en (buf_irq_en),
        .shf_irq_en (shf_irq_en),
        .tx_line    (tx_line),
        .buf_empty  (buf_empty),
        .shf_empty  (shf_empty),
        .overflow   (overflow),
        .irq        (irq),
        .irq_cause  (irq_cause)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // expected line level k cycles after the first start-bit cycle
    function automatic logic exp_bit(input int k, input int per, input int nb);
        int slots = nb + 2;
        int fr = k / (slots * per);
        int slot = (k / per) % slots;
        if (slot == 0) return 1'b0;
        if (slot == slots - 1) return 1'b1;
        return pat[fr][slot-1];
    endfunction

    task automatic send_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = pat[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2 R3 R5 R7: record nf contiguous frames, compare every cycle
    task automatic capture(input int nf, input int nb, input int per, input string req);
        int w = 0;
        int total = nf * (nb + 2) * per;
        int bad = -1;
        do begin
            @(negedge clk);
            w++;
        end while (tx_line !== 1'b0 && w < 2000);
        samp[0] = tx_line;
        for (int k = 1; k < total; k++) begin
            @(negedge clk);
            samp[k] = tx_line;
        end
        check({req, " last stop cycle shifter busy (R7)"}, shf_empty, 1'b0);
        for (int k = 0; k < total; k++) begin
            if (bad < 0 && samp[k] !== exp_bit(k, per, nb)) bad = k;
        end
        if (bad >= 0) begin
            check({req, " frame stream"}, samp[bad], exp_bit(bad, per, nb));
        end else begin
            check({req, " frame stream"}, 1'b1, 1'b1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx", tx_line, 1'b1);
        check("R1 buf_empty", buf_empty, 1'b1);
        check("R1 shf_empty", shf_empty, 1'b1);
        check("R1 overflow", overflow, 1'b0);
        check("R1 irq", {irq, irq_cause}, 3'b000);

        // R8 enable sweep with both flags set
        for (int en = 0; en < 4; en++) begin
            buf_irq_en = en[0];
            shf_irq_en = en[1];
            #1;
            check("R8 idle gating", {irq, irq_cause}, {(en != 0), en[1], en[0]});
        end
        buf_irq_en = 1'b0;
        shf_irq_en = 1'b0;

        // R2 R3 R5 sweep over length and divisor
        for (int ln = 0; ln < 2; ln++) begin
            for (int di = 0; di < 5; di++) begin
                int dv = (di == 4) ? 5 : di;
                int per = (dv == 0) ? 1 : dv;
                @(negedge clk);
                divisor = 16'(dv);
                len8 = ln[0];
                for (int i = 0; i < 3; i++) pat[i] = 8'(i * 73 + dv * 29 + ln * 101 + 128);
                fork
                    send_burst(3);
                    capture(3, ln ? 8 : 7, per, ln ? "R2 R3 R5 8bit" : "R2 R3 R5 7bit");
                join
                @(negedge clk);
                check("R7 flags after burst", {buf_empty, shf_empty, tx_line}, 3'b111);
            end
        end

        // R4 auto-load timing, divisor 4, 8 bits
        divisor = 16'd4;
        len8 = 1'b1;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'hA5;
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 after write edge", {buf_empty, shf_empty, tx_line}, 3'b011);
        @(negedge clk);
        check("R4 after load edge", {buf_empty, shf_empty, tx_line}, 3'b000);
        repeat (45) @(negedge clk);
        check("R4 R7 frame drained", {buf_empty, shf_empty, tx_line}, 3'b111);

        // R6 two bytes, divisor 2: frame 20 cycles
        divisor = 16'd2;
        pat[0] = 8'h3C;
        pat[1] = 8'hC3;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = pat[0];
        @(negedge clk);
        wr_data = pat[1];
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 start bit", tx_line, 1'b0);
        repeat (19) @(negedge clk);
        check("R6 before stop end", {buf_empty, shf_empty}, 2'b00);
        @(negedge clk);
        check("R6 last byte handed over", {buf_empty, shf_empty, tx_line}, 3'b100);
        buf_irq_en = 1'b1;
        shf_irq_en = 1'b1;
        #1;
        check("R8 buffer cause only", {irq, irq_cause}, 3'b101);
        buf_irq_en = 1'b0;
        shf_irq_en = 1'b0;
        repeat (20) @(negedge clk);
        check("R6 R7 both set", {buf_empty, shf_empty}, 2'b11);

        // R6 three bytes, divisor 1, 7 bits: frame 9 cycles
        divisor = 16'd1;
        len8 = 1'b0;
        pat[0] = 8'h11;
        pat[1] = 8'h22;
        pat[2] = 8'h44;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = pat[0];
        @(negedge clk);
        wr_data = pat[1];
        @(negedge clk);
        wr_data = pat[2];
        check("R4 first start bit", tx_line, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        buf_irq_en = 1'b1;
        shf_irq_en = 1'b1;
        #1;
        check("R8 mid frame no cause", {irq, irq_cause}, 3'b000);
        buf_irq_en = 1'b0;
        shf_irq_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 R6 two left stays clear", {buf_empty, shf_empty, tx_line}, 3'b000);
        repeat (9) @(negedge clk);
        check("R5 R6 last handed over", {buf_empty, shf_empty, tx_line}, 3'b100);
        repeat (9) @(negedge clk);
        check("R6 R7 drained", {buf_empty, shf_empty, tx_line}, 3'b111);

        // R9 overflow: divisor 4, 8 bits, 18 back-to-back writes
        divisor = 16'd4;
        len8 = 1'b1;
        for (int i = 0; i < 18; i++) pat[i] = 8'(i * 37 + 5);
        fork
            begin
                for (int i = 0; i < 17; i++) begin
                    @(negedge clk);
                    wr_en = 1'b1;
                    wr_data = pat[i];
                end
                @(negedge clk);
                check("R9 seventeen fit", overflow, 1'b0);
                wr_data = pat[17];
                @(negedge clk);
                wr_en = 1'b0;
                check("R9 eighteenth dropped", overflow, 1'b1);
            end
            capture(17, 8, 4, "R9 R5 seventeen frames");
        join
        @(negedge clk);
        check("R9 drained flags sticky ovf", {buf_empty, shf_empty, overflow}, 3'b111);
        begin
            int lows = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (tx_line !== 1'b1) lows++;
            end
            check("R9 dropped byte never sent", lows, 0);
        end

        // R1 reset clears overflow
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R9 overflow cleared", {overflow, buf_empty, shf_empty}, 3'b011);

        finish_run();
    end

endmodule